// File: doc/BRIEF.md
# ADC Test Pattern Multiplexer

This block sits in the sample path between an ADC and the capture logic that packs samples into outgoing packets. Each clock it delivers one 32-bit word to the capture side. In normal operation that word is the live ADC sample. For bring-up and link debugging, a 4-bit pattern-select field can swap the live data for a known pattern: a toggling checkerboard, a fixed half-high word, masked pseudo-random words, an echo of the capture logic's remaining-packet count, or a distinctive filler word.

The pattern select is loaded through a simple register write port. The field sits in bits 27:24 of the written word, so writing 0x01000001 selects pattern 1. The random patterns come from a maximal-length 32-bit LFSR that steps once per clock from a nonzero seed. The output is registered, so every result appears one clock after the inputs that produced it.

Top module: `adc_test_pattern_mux`

## Requirements
- R1: While `rst_n` is low at a clock edge, `data_out` becomes 0 at that edge, and the pattern select returns to 0 (live data).
- R2: A clock edge with `cfg_wr_en` high loads `cfg_wr_data[27:24]` into the pattern select. The other bits of `cfg_wr_data` are ignored, and the select keeps its value while `cfg_wr_en` is low.
- R3: With select 0, `data_out` equals the `adc_word` that was present at the previous clock edge.
- R4: With select 1, `data_out` alternates every clock between 0xAAAA5555 and 0x5555AAAA.
- R5: With select 2, `data_out` is 0xFFFF0000.
- R6: With select 3, `data_out[31]` is 0 and `data_out[30:0]` is pseudo-random, with a new value every clock.
- R7: With select 5, `data_out[31:15]` is 0 and `data_out[14:0]` is pseudo-random.
- R8: With select 9, `data_out` equals `pkt_left`, zero-extended, as sampled at the previous clock edge.
- R9: Any select value not in {0, 1, 2, 3, 5, 9} gives `data_out` = 0xF8F8F8F8.
- R10: The random source is a 32-bit Galois LFSR with polynomial x^32+x^22+x^2+x+1. It is loaded with a nonzero seed on reset, steps every clock, and never holds zero.
- R11: A select written at clock edge k governs the `data_out` value produced at edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_word | input | 32 | Live ADC sample |
| pkt_left | input | CNT_W (16) | Remaining raw-data packet count from the capture logic |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 32 | Control register write value; bits 27:24 hold the pattern select |
| data_out | output | 32 | Registered sample word toward the capture logic |

## Verification
The assertions assume that `adc_word`, `pkt_left`, `cfg_wr_en` and `cfg_wr_data` are known and stable around each rising edge. They also assume that reset is held for at least one edge before normal operation. The stimulus drives every input at the falling edge, holds reset low for several clocks at the start and again near the end, and changes the select only through single-cycle write pulses. Those pulses carry noise in the bits outside the select field, and the select bits are also driven while the strobe is low. The random patterns are judged by their masks and by whether successive words differ, so no check depends on the exact LFSR phase.

// File: rtl/atpm_pkg.sv
// Package: shared constants for the ADC test pattern multiplexer.
// Assumes a 32-bit sample word; pattern codes are fixed by software.
package atpm_pkg;

    localparam int SEL_W = 4;

    // Pattern select codes (software-visible, must not move).
    localparam logic [SEL_W-1:0] SEL_LIVE    = 4'd0;
    localparam logic [SEL_W-1:0] SEL_CHECKER = 4'd1;
    localparam logic [SEL_W-1:0] SEL_HIHALF  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_RAND31  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_RAND15  = 4'd5;
    localparam logic [SEL_W-1:0] SEL_COUNT   = 4'd9;

    // Fixed pattern words.
    localparam logic [31:0] WORD_CHK_A  = 32'hAAAA5555;
    localparam logic [31:0] WORD_CHK_B  = 32'h5555AAAA;
    localparam logic [31:0] WORD_HIHALF = 32'hFFFF0000;
    localparam logic [31:0] WORD_FILL   = 32'hF8F8F8F8;

    // Random generator defaults: x^32+x^22+x^2+x+1 in right-shift Galois form.
    localparam logic [31:0] RND_TAPS = 32'h80200003;
    localparam logic [31:0] RND_SEED = 32'h1ACEB00C;

    // Number of zero bits above the narrow random field.
    localparam int NARROW_ZERO_W = 17;

endpackage

// File: rtl/atpm_sel_reg.sv
// Module: pattern select register.
// Captures the select field from a control word on a write strobe.
// Assumes the field lies fully inside the write word.
module atpm_sel_reg #(
    parameter int WORD_W  = 32,
    parameter int SEL_W   = 4,
    parameter int SEL_LSB = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel_q
);

    localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

    // Load the select field on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en) begin
            sel_q <= wr_data[SEL_MSB:SEL_LSB];
        end
    end

endmodule

// File: rtl/atpm_lfsr.sv
// Module: Galois LFSR, one step per clock.
// Assumes TAPS describes a maximal-length polynomial and SEED is nonzero.
module atpm_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h80200003,
    parameter logic [W-1:0] SEED = 32'h1ACEB00C
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_q
);

    logic [W-1:0] nxt;
    logic         fb;

    assign fb = state_q[0];

    // Per-bit feedback: shift right, xor taps when the dropped bit is 1.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_top
            assign nxt[i] = TAPS[i] & fb;
        end else begin : g_mid
            assign nxt[i] = state_q[i+1] ^ (TAPS[i] & fb);
        end
    end

    // Advance the generator every clock; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= nxt;
        end
    end

endmodule

// File: rtl/atpm_phase.sv
// Module: checkerboard phase toggle.
// Flips every clock so the checkerboard words alternate.
module atpm_phase (
    input  logic clk,
    input  logic rst_n,
    output logic phase_q
);

    // Toggle each clock; start low after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

endmodule

// File: rtl/atpm_select.sv
// Module: combinational pattern selector.
// Picks the next output word from the select code and the candidate sources.
// Assumes CNT_W <= WORD_W and that the narrow random field is non-empty.
module atpm_select
    import atpm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              phase,
    input  logic [WORD_W-1:0] live,
    input  logic [CNT_W-1:0]  count,
    input  logic [WORD_W-1:0] rnd,
    output logic [WORD_W-1:0] word
);

    localparam int NARROW_W = WORD_W - NARROW_ZERO_W;
    localparam int PAD_W    = WORD_W - CNT_W;

    logic [WORD_W-1:0] rnd_wide;
    logic [WORD_W-1:0] rnd_narrow;
    logic [WORD_W-1:0] cnt_ext;
    logic [WORD_W-1:0] chk_word;

    assign rnd_wide   = {1'b0, rnd[WORD_W-2:0]};
    assign rnd_narrow = {{NARROW_ZERO_W{1'b0}}, rnd[NARROW_W-1:0]};
    assign cnt_ext    = {{PAD_W{1'b0}}, count};
    assign chk_word   = phase ? WORD_CHK_B[WORD_W-1:0] : WORD_CHK_A[WORD_W-1:0];

    // Decode the select code into the next output word.
    always_comb begin
        case (sel)
            SEL_LIVE:    word = live;
            SEL_CHECKER: word = chk_word;
            SEL_HIHALF:  word = WORD_HIHALF[WORD_W-1:0];
            SEL_RAND31:  word = rnd_wide;
            SEL_RAND15:  word = rnd_narrow;
            SEL_COUNT:   word = cnt_ext;
            default:     word = WORD_FILL[WORD_W-1:0];
        endcase
    end

endmodule

// File: rtl/adc_test_pattern_mux.sv
// Module: ADC test pattern multiplexer (top).
// Replaces live ADC words with test patterns chosen by a select field in a
// control word. The output is registered, with one clock of latency.
// Assumes synchronous active-low reset held for at least one edge.
module adc_test_pattern_mux
    import atpm_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          CNT_W   = 16,
    parameter int          SEL_LSB = 24,
    parameter logic [31:0] SEED    = RND_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] adc_word,
    input  logic [CNT_W-1:0]  pkt_left,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wr_data,
    output logic [DATA_W-1:0] data_out
);

    logic [SEL_W-1:0]  mode_q;
    logic [DATA_W-1:0] rnd_word;
    logic              phase_q;
    logic [DATA_W-1:0] next_word;

    atpm_sel_reg #(
        .WORD_W (DATA_W),
        .SEL_W  (SEL_W),
        .SEL_LSB(SEL_LSB)
    ) u_sel_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_data(cfg_wr_data),
        .sel_q  (mode_q)
    );

    atpm_lfsr #(
        .W   (DATA_W),
        .TAPS(RND_TAPS[DATA_W-1:0]),
        .SEED(SEED[DATA_W-1:0])
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .state_q(rnd_word)
    );

    atpm_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_q(phase_q)
    );

    atpm_select #(
        .WORD_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_select (
        .sel  (mode_q),
        .phase(phase_q),
        .live (adc_word),
        .count(pkt_left),
        .rnd  (rnd_word),
        .word (next_word)
    );

    // Register the selected word toward the capture logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
        end else begin
            data_out <= next_word;
        end
    end

endmodule

// File: rtl/atpm_chk.sv
// Module: assertion checker for the ADC test pattern multiplexer.
// Bound to the top; observes ports and the select and random state.
module atpm_chk
    import atpm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int SEL_LSB = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  mode_q,
    input logic [DATA_W-1:0] adc_word,
    input logic [CNT_W-1:0]  pkt_count,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] data_out,
    input logic [DATA_W-1:0] rnd_state
);

    localparam int NARROW_W = DATA_W - NARROW_ZERO_W;

    logic known_sel;
    assign known_sel = (mode_q == SEL_LIVE) || (mode_q == SEL_CHECKER) ||
                       (mode_q == SEL_HIHALF) || (mode_q == SEL_RAND31) ||
                       (mode_q == SEL_RAND15) || (mode_q == SEL_COUNT);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (data_out == '0) && (mode_q == '0));

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mode_q == $past(wr_data[SEL_LSB+SEL_W-1:SEL_LSB]));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));

    // R3
    live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_LIVE) |=> data_out == $past(adc_word));

    // R4
    checker_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_CHECKER && $past(mode_q) == SEL_CHECKER &&
         data_out == WORD_CHK_A[DATA_W-1:0])
        |=> data_out == WORD_CHK_B[DATA_W-1:0]);

    // R5
    hihalf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_HIHALF) |=> data_out == WORD_HIHALF[DATA_W-1:0]);

    // R6
    rand31_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_RAND31) |=> !data_out[DATA_W-1]);

    // R7
    rand15_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_RAND15) |=> data_out[DATA_W-1:NARROW_W] == '0);

    // R8
    count_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_COUNT) |=>
        data_out == {{(DATA_W-CNT_W){1'b0}}, $past(pkt_count)});

    // R9
    filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !known_sel |=> data_out == WORD_FILL[DATA_W-1:0]);

    // R10
    rnd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_state != '0);

    // R10
    rnd_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> rnd_state != $past(rnd_state));

endmodule

bind adc_test_pattern_mux atpm_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .SEL_LSB(SEL_LSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .adc_word (adc_word),
    .pkt_count(pkt_left),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .data_out (data_out),
    .rnd_state(rnd_word)
);

// File: tb/adc_test_pattern_mux_bench.sv
// Scoreboard bench: driver tasks queue expectations, monitor compares.
module adc_test_pattern_mux_bench;

    localparam int K_SKIP  = 0;
    localparam int K_EXACT = 1;
    localparam int K_CHK   = 2;
    localparam int K_RND31 = 3;
    localparam int K_RND15 = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] adc_word = '0;
    logic [15:0] pkt_left = '0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] data_out;

    int n_checks = 0;
    int n_fails  = 0;
    exp_t q[$];
    logic [31:0] prev_out = '0;
    int          prev_kind = K_SKIP;
    int          rnd31_changes = 0;

    always #5 clk = ~clk;

    adc_test_pattern_mux u_adc_test_pattern_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .adc_word   (adc_word),
        .pkt_left   (pkt_left),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_data(cfg_wr_data),
        .data_out   (data_out)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: after each edge, pop one expectation and compare.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            case (it.kind)
                K_EXACT: check(data_out === it.exp, it.req, data_out, it.exp);
                K_CHK: begin
                    check(data_out === 32'hAAAA5555 || data_out === 32'h5555AAAA,
                          it.req, data_out, 32'hAAAA5555);
                    if (prev_kind == K_CHK)
                        check(data_out !== prev_out, it.req, data_out, ~prev_out);
                end
                K_RND31: begin
                    check(data_out[31] === 1'b0, it.req, data_out, {1'b0, data_out[30:0]});
                    if (prev_kind == K_RND31 && data_out !== prev_out)
                        rnd31_changes++;
                end
                K_RND15: check(data_out[31:15] === 17'd0, it.req, data_out,
                               {17'd0, data_out[14:0]});
                default: ;
            endcase
            prev_out  = data_out;
            prev_kind = it.kind;
        end
    end

    // Drive one clock of inputs and queue the expected output.
    task automatic step(input int kind, input logic [31:0] exp, input string req,
                        input logic [31:0] adc, input logic [15:0] cnt);
        exp_t it;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wr_data = 32'h0F00_0000 ^ adc;
        adc_word    = adc;
        pkt_left    = cnt;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        q.push_back(it);
    endtask

    // One-cycle write pulse; the output at that edge still uses the old select.
    task automatic write_sel(input logic [31:0] val);
        exp_t it;
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = val;
        it.kind = K_SKIP;
        it.exp  = '0;
        it.req  = "R2";
        q.push_back(it);
    endtask

    task automatic drain();
        repeat (3) @(posedge clk);
        #3;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] a;
        logic [15:0] c;
        repeat (4) @(posedge clk);
        #3;
        // R1: output cleared during reset
        check(data_out === 32'd0, "R1", data_out, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R3: select is 0 after reset -> live pass-through
        for (int i = 0; i < 8; i++) begin
            a = $urandom;
            step(K_EXACT, a, "R3", a, 16'(i));
        end

        // R2/R11/R4: bits above the field are noise; checkerboard next edge
        write_sel(32'hF1FF_FFFF);
        for (int i = 0; i < 8; i++) step(K_CHK, '0, "R4", $urandom, 16'd0);

        // R5 half-high constant
        write_sel(32'h0200_0000);
        for (int i = 0; i < 5; i++) step(K_EXACT, 32'hFFFF0000, "R5", $urandom, 16'd7);

        // R2: select held while strobe low though data bits carry 0xF
        for (int i = 0; i < 3; i++) step(K_EXACT, 32'hFFFF0000, "R2", 32'h0000_0000, 16'd1);

        // R6/R10 wide random
        write_sel(32'h0300_0001);
        for (int i = 0; i < 20; i++) step(K_RND31, '0, "R6", $urandom, 16'd0);

        // R7 narrow random
        write_sel(32'h0500_0001);
        for (int i = 0; i < 20; i++) step(K_RND15, '0, "R7", $urandom, 16'd0);

        // R8 count echo, including extremes
        write_sel(32'h0900_0001);
        step(K_EXACT, 32'h0000_0000, "R8", $urandom, 16'h0000);
        step(K_EXACT, 32'h0000_FFFF, "R8", $urandom, 16'hFFFF);
        for (int i = 0; i < 6; i++) begin
            c = 16'($urandom);
            step(K_EXACT, {16'd0, c}, "R8", $urandom, c);
        end

        // R9 every unassigned select gives the filler
        for (int m = 4; m < 16; m++) begin
            if (m != 5 && m != 9) begin
                write_sel({4'h0, 4'(m), 24'h000001});
                step(K_EXACT, 32'hF8F8F8F8, "R9", $urandom, 16'd3);
                step(K_EXACT, 32'hF8F8F8F8, "R9", $urandom, 16'd4);
            end
        end

        // R11: back to live; first word after the write edge is live
        write_sel(32'h0000_0000);
        a = 32'h1234_5678;
        step(K_EXACT, a, "R11", a, 16'd0);
        drain();

        // R10: wide random words changed across the run
        check(rnd31_changes >= 18, "R10", 32'(rnd31_changes), 32'd19);

        // R1: reset mid-run clears output and select
        write_sel(32'h0200_0000);
        step(K_EXACT, 32'hFFFF0000, "R5", 32'd0, 16'd0);
        drain();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #3;
        check(data_out === 32'd0, "R1", data_out, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        a = 32'hCAFE_0001;
        step(K_EXACT, a, "R1", a, 16'd0);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule